// File: doc/BRIEF.md
# Two-Mode Page Translation Unit

This unit sits between a processor's logical address bus and physical memory. A 16-bit logical address is split into a 4-bit page number and a 12-bit offset. The page number indexes one of two writable tables, one for supervisor state and one for user state, chosen by a status input. The table supplies an 8-bit physical page number, and the offset passes through unchanged, giving a 20-bit physical address. In user state, a deny bit kept with each user entry can refuse the access. The unit then raises a fault flag and holds back the memory select.

The tables sit in a 64-byte register window at logical 0xFFC0–0xFFFF. The window is matched on the raw logical address, so no mapping can move or hide it. Only supervisor state can write or read the window. A banked mode can replace page translation: the upper half of the logical space becomes a 32K window whose physical position is set by a 4-bit bank value.

Window layout, by offset within the window:
- 0x00–0x0F: supervisor page numbers, one per page, in page order.
- 0x10–0x1F: user page numbers.
- 0x20–0x2F: user deny flags, in data bit 0.
- 0x30: bank-mode enable, in bit 0.
- 0x31: bank value, in bits 3:0.

All other offsets read as zero, and writes to them are dropped.

Top module: `mmu_page_xlate`

## Requirements
- R1: When `mem_sel` is high, `pa[11:0]` equals `la[11:0]`.
- R2: With bank mode off and `super_mode`=1, `pa[19:12]` is the supervisor entry for page `la[15:12]`.
- R3: With bank mode off and `super_mode`=0, `pa[19:12]` is the user entry for page `la[15:12]`.
- R4: After reset, supervisor entry i holds i (identity mapping), and bank mode is off with bank value 0.
- R5: After reset, every user deny flag reads 1 and every user page number reads 0.
- R6: Any request with `la` in 0xFFC0–0xFFFF leaves `mem_sel` low, whatever the tables or mode hold.
- R7: A supervisor write to the window changes the addressed entry from the next clock edge. A supervisor read of the window returns the entry on `rdata` in the same cycle.
- R8: A user-state write to the window raises `fault`, keeps `mem_sel` low and changes no entry. A user-state read of the window returns 0 with no fault.
- R9: A user-state request outside the window to a page whose deny flag is 1 raises `fault` and keeps `mem_sel` low. With the flag at 0, the request gets `mem_sel`=1 and `fault`=0. Supervisor requests outside the window are never denied.
- R10: With the bank enable at 1, `la[15]`=1 maps to `pa` = {0, bank, `la[14:0]`} and `la[15]`=0 maps to `pa` = `la` zero-extended. For example, bank 0x3 with `la`=0xC000 gives `pa`=0x1C000.
- R11: With `req` low, `mem_sel`, `fault` and `rdata` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Bus access valid this cycle |
| we | input | 1 | 1 = write, 0 = read |
| la | input | 16 | Logical address |
| wdata | input | 8 | Write data to the register window |
| super_mode | input | 1 | 1 = supervisor state, 0 = user state |
| pa | output | 20 | Physical address |
| mem_sel | output | 1 | Physical memory access granted |
| fault | output | 1 | Denied access or user-state window write |
| rdata | output | 8 | Register window read data |

## Verification
Translation, `mem_sel`, `fault` and window read data are combinational, so each is due in the same cycle as its request. The bench drives inputs after the falling edge and samples one nanosecond later, before the next rising edge. A window write takes effect at the rising edge that ends its cycle. The bench model updates its own tables at that same edge, so the next request is checked against the new contents. Directed sequences cover reset contents, the banked example, rejected user writes confirmed by a later readback, and deny toggling. A seeded random stream mixes all of these.

// File: rtl/mmu_pkg.sv
// Package: shared types for the page translation unit.
// Assumes the register window is split into four groups of one page-count each.
package mmu_pkg;

    // Register groups inside the window; the group order follows the window layout.
    typedef enum logic [2:0] {
        GRP_NONE = 3'd0,
        GRP_SUP  = 3'd1,
        GRP_USR  = 3'd2,
        GRP_DENY = 3'd3,
        GRP_MODE = 3'd4,
        GRP_BANK = 3'd5
    } win_grp_e;

endpackage

// File: rtl/mmu_win_dec.sv
// Module: register window decoder.
// Matches the raw logical address against the fixed window base and names the
// register group and page index addressed. Assumes WIN_AW == PAGE_W + 2.
module mmu_win_dec
    import mmu_pkg::*;
#(
    parameter int          LA_W     = 16,
    parameter int          PAGE_W   = 4,
    parameter int          WIN_AW   = PAGE_W + 2,
    parameter logic [15:0] WIN_BASE = 16'hFFC0
) (
    input  logic [LA_W-1:0]   la,
    output logic              hit,
    output win_grp_e          grp,
    output logic [PAGE_W-1:0] idx
);

    localparam int GRP_W = WIN_AW - PAGE_W;

    logic [GRP_W-1:0] grp_code;

    // Window match and split of the window offset into group and index.
    always_comb begin
        hit      = (la[LA_W-1:WIN_AW] == WIN_BASE[LA_W-1:WIN_AW]);
        grp_code = la[WIN_AW-1:PAGE_W];
        idx      = la[PAGE_W-1:0];
    end

    // Group selection; the last group holds the two mode registers.
    always_comb begin
        unique case (grp_code)
            GRP_W'(0): grp = GRP_SUP;
            GRP_W'(1): grp = GRP_USR;
            GRP_W'(2): grp = GRP_DENY;
            default: begin
                if (idx == PAGE_W'(0))      grp = GRP_MODE;
                else if (idx == PAGE_W'(1)) grp = GRP_BANK;
                else                        grp = GRP_NONE;
            end
        endcase
    end

endmodule

// File: rtl/mmu_tables.sv
// Module: translation storage.
// Holds the supervisor and user page tables, the user deny flags and the bank
// registers. Provides a lookup port by logical page and a readback port by
// window index. Assumes the write enable is already qualified by supervisor state.
module mmu_tables
    import mmu_pkg::*;
#(
    parameter int PAGE_W = 4,
    parameter int PPN_W  = 8,
    parameter int DATA_W = 8,
    parameter int BANK_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  win_grp_e          grp,
    input  logic [PAGE_W-1:0] win_idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PAGE_W-1:0] lk_page,
    output logic [PPN_W-1:0]  sup_ppn,
    output logic [PPN_W-1:0]  usr_ppn,
    output logic              usr_deny,
    output logic              bank_en,
    output logic [BANK_W-1:0] bank_val,
    output logic [DATA_W-1:0] rd_data
);

    localparam int NPAGES = 1 << PAGE_W;

    logic [PPN_W-1:0]  sup_tab [NPAGES];
    logic [PPN_W-1:0]  usr_tab [NPAGES];
    logic [NPAGES-1:0] deny_vec;
    logic [NPAGES-1:0] sel_vec;

    // Per-entry index match, one per page.
    for (genvar g = 0; g < NPAGES; g++) begin : g_sel
        assign sel_vec[g] = (win_idx == PAGE_W'(g));
    end

    // Table and register update: identity and full denial on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NPAGES; i++) begin
                sup_tab[i] <= PPN_W'(i);
                usr_tab[i] <= '0;
            end
            deny_vec <= '1;
            bank_en  <= 1'b0;
            bank_val <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < NPAGES; i++) begin
                if (sel_vec[i] && grp == GRP_SUP)  sup_tab[i]  <= PPN_W'(wdata);
                if (sel_vec[i] && grp == GRP_USR)  usr_tab[i]  <= PPN_W'(wdata);
                if (sel_vec[i] && grp == GRP_DENY) deny_vec[i] <= wdata[0];
            end
            if (grp == GRP_MODE) bank_en  <= wdata[0];
            if (grp == GRP_BANK) bank_val <= wdata[BANK_W-1:0];
        end
    end

    // Lookup by logical page for translation.
    always_comb begin
        sup_ppn  = sup_tab[lk_page];
        usr_ppn  = usr_tab[lk_page];
        usr_deny = deny_vec[lk_page];
    end

    // Readback by window index.
    always_comb begin
        unique case (grp)
            GRP_SUP:  rd_data = DATA_W'(sup_tab[win_idx]);
            GRP_USR:  rd_data = DATA_W'(usr_tab[win_idx]);
            GRP_DENY: rd_data = DATA_W'(deny_vec[win_idx]);
            GRP_MODE: rd_data = DATA_W'(bank_en);
            GRP_BANK: rd_data = DATA_W'(bank_val);
            default:  rd_data = '0;
        endcase
    end

    // R7
    sup_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && grp == GRP_SUP) |=> (sup_tab[$past(win_idx)] == PPN_W'($past(wdata))));

endmodule

// File: rtl/mmu_xlate.sv
// Module: address formation.
// Builds the physical address from the page table result or, in bank mode,
// from the bank value, and flags user-state denial. Purely combinational.
// Assumes PA width covers the bank value above a window of LA_W-1 bits.
module mmu_xlate #(
    parameter int LA_W   = 16,
    parameter int PAGE_W = 4,
    parameter int PPN_W  = 8,
    parameter int BANK_W = 4,
    parameter int OFF_W  = LA_W - PAGE_W,
    parameter int PA_W   = PPN_W + OFF_W
) (
    input  logic [LA_W-1:0]   la,
    input  logic              super_mode,
    input  logic [PPN_W-1:0]  sup_ppn,
    input  logic [PPN_W-1:0]  usr_ppn,
    input  logic              usr_deny,
    input  logic              bank_en,
    input  logic [BANK_W-1:0] bank_val,
    output logic [PA_W-1:0]   pa,
    output logic              deny_hit
);

    logic [PPN_W-1:0] page_ppn;

    // Table choice by processor state.
    always_comb page_ppn = super_mode ? sup_ppn : usr_ppn;

    // Physical address: banked window, plain lower half, or paged.
    always_comb begin
        if (bank_en) begin
            if (la[LA_W-1]) pa = PA_W'({bank_val, la[LA_W-2:0]});
            else            pa = PA_W'(la);
        end else begin
            pa = {page_ppn, la[OFF_W-1:0]};
        end
    end

    // Denial applies to user state only.
    always_comb deny_hit = !super_mode && usr_deny;

endmodule

// File: rtl/mmu_page_xlate.sv
// Module: two-mode page translation unit (top).
// Translates logical to physical addresses through a supervisor or user table,
// serves the fixed register window, and raises a fault on denied or illegal
// accesses. All outputs are combinational in the request cycle; window writes
// take effect at the next rising edge.
module mmu_page_xlate
    import mmu_pkg::*;
#(
    parameter int          LA_W     = 16,
    parameter int          PAGE_W   = 4,
    parameter int          PPN_W    = 8,
    parameter int          DATA_W   = 8,
    parameter int          BANK_W   = 4,
    parameter logic [15:0] WIN_BASE = 16'hFFC0,
    localparam int         OFF_W    = LA_W - PAGE_W,
    localparam int         PA_W     = PPN_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [LA_W-1:0]   la,
    input  logic [DATA_W-1:0] wdata,
    input  logic              super_mode,
    output logic [PA_W-1:0]   pa,
    output logic              mem_sel,
    output logic              fault,
    output logic [DATA_W-1:0] rdata
);

    localparam int WIN_AW = PAGE_W + 2;

    logic              win_hit;
    win_grp_e          win_grp;
    logic [PAGE_W-1:0] win_idx;
    logic              tab_wr;
    logic [PPN_W-1:0]  sup_ppn;
    logic [PPN_W-1:0]  usr_ppn;
    logic              usr_deny;
    logic              bank_en;
    logic [BANK_W-1:0] bank_val;
    logic [DATA_W-1:0] tab_rd;
    logic              deny_hit;

    mmu_win_dec #(
        .LA_W(LA_W), .PAGE_W(PAGE_W), .WIN_AW(WIN_AW), .WIN_BASE(WIN_BASE)
    ) i_dec (
        .la(la), .hit(win_hit), .grp(win_grp), .idx(win_idx)
    );

    // Window writes only from supervisor state.
    always_comb tab_wr = req && we && win_hit && super_mode;

    mmu_tables #(
        .PAGE_W(PAGE_W), .PPN_W(PPN_W), .DATA_W(DATA_W), .BANK_W(BANK_W)
    ) i_tab (
        .clk(clk), .rst_n(rst_n), .wr_en(tab_wr), .grp(win_grp),
        .win_idx(win_idx), .wdata(wdata), .lk_page(la[LA_W-1:OFF_W]),
        .sup_ppn(sup_ppn), .usr_ppn(usr_ppn), .usr_deny(usr_deny),
        .bank_en(bank_en), .bank_val(bank_val), .rd_data(tab_rd)
    );

    mmu_xlate #(
        .LA_W(LA_W), .PAGE_W(PAGE_W), .PPN_W(PPN_W), .BANK_W(BANK_W)
    ) i_xl (
        .la(la), .super_mode(super_mode), .sup_ppn(sup_ppn), .usr_ppn(usr_ppn),
        .usr_deny(usr_deny), .bank_en(bank_en), .bank_val(bank_val),
        .pa(pa), .deny_hit(deny_hit)
    );

    // Grant, fault and readback for the current request.
    always_comb begin
        mem_sel = req && !win_hit && !deny_hit;
        fault   = req && ((win_hit && we && !super_mode) || (!win_hit && deny_hit));
        rdata   = (req && !we && win_hit && super_mode) ? tab_rd : '0;
    end

    // R6
    window_never_selects_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && la[LA_W-1:WIN_AW] == WIN_BASE[LA_W-1:WIN_AW]) |-> !mem_sel);

    // R8
    user_window_write_faults_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we && !super_mode && win_hit) |-> (fault && !mem_sel));

    // R9
    fault_excludes_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fault && mem_sel));

    // R9
    user_deny_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !super_mode && !win_hit && usr_deny) |-> (fault && !mem_sel));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req |-> (!mem_sel && !fault && rdata == '0));

    // R1
    offset_passes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_sel && !bank_en) |-> (pa[OFF_W-1:0] == la[OFF_W-1:0]));

endmodule

// File: tb/test_mmu_page_xlate.sv
`timescale 1ns/1ps
module test_mmu_page_xlate;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [15:0] la = '0;
    logic [7:0]  wdata = '0;
    logic        super_mode = 1'b1;
    logic [19:0] pa;
    logic        mem_sel;
    logic        fault;
    logic [7:0]  rdata;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Bench model of the programmable state.
    logic [7:0] m_sup [16];
    logic [7:0] m_usr [16];
    logic       m_deny [16];
    logic       m_bank_en;
    logic [3:0] m_bank;

    always #2.5 clk = ~clk;

    mmu_page_xlate i_mmu_page_xlate (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .la(la), .wdata(wdata),
        .super_mode(super_mode), .pa(pa), .mem_sel(mem_sel), .fault(fault),
        .rdata(rdata)
    );

    function automatic bit is_win(input logic [15:0] a);
        return a[15:6] == 10'h3FF;
    endfunction

    function automatic logic [7:0] m_read(input logic [15:0] a);
        case (a[5:4])
            2'd0: return m_sup[a[3:0]];
            2'd1: return m_usr[a[3:0]];
            2'd2: return {7'd0, m_deny[a[3:0]]};
            default: begin
                if (a[3:0] == 4'd0) return {7'd0, m_bank_en};
                if (a[3:0] == 4'd1) return {4'd0, m_bank};
                return 8'd0;
            end
        endcase
    endfunction

    function automatic logic [19:0] m_pa(input logic [15:0] a, input logic s);
        if (m_bank_en) return a[15] ? {1'b0, m_bank, a[14:0]} : {4'd0, a};
        return {(s ? m_sup[a[15:12]] : m_usr[a[15:12]]), a[11:0]};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 16; i++) begin
            m_sup[i] = 8'(i);
            m_usr[i] = 8'd0;
            m_deny[i] = 1'b1;
        end
        m_bank_en = 1'b0;
        m_bank = 4'd0;
    endtask

    // One bus cycle: drive after the falling edge, check, then let the edge commit.
    task automatic access(input logic r, input logic w, input logic [15:0] a,
                          input logic [7:0] d, input logic s);
        logic win;
        logic e_sel;
        logic e_fault;
        logic [7:0] e_rd;
        req = r; we = w; la = a; wdata = d; super_mode = s;
        #1;
        win = is_win(a);
        e_sel = r && !win && !(!s && m_deny[a[15:12]]);
        e_fault = r && ((win && w && !s) || (!win && !s && m_deny[a[15:12]]));
        e_rd = (r && !w && win && s) ? m_read(a) : 8'd0;
        if (!r) chk("R11 idle", {mem_sel, fault, rdata}, 10'd0);
        else if (win) chk("R6 window select", mem_sel, e_sel);
        else chk("R9 select", mem_sel, e_sel);
        chk(w && !s ? "R8 fault" : "R9 fault", fault, e_fault);
        chk(s ? "R7 readback" : "R8 user read", rdata, e_rd);
        if (e_sel) begin
            if (m_bank_en) chk("R10 bank pa", pa, m_pa(a, s));
            else if (s) chk("R2 R1 supervisor pa", pa, m_pa(a, s));
            else chk("R3 R1 user pa", pa, m_pa(a, s));
        end
        @(posedge clk);
        if (r && w && win && s) begin
            case (a[5:4])
                2'd0: m_sup[a[3:0]] = d;
                2'd1: m_usr[a[3:0]] = d;
                2'd2: m_deny[a[3:0]] = d[0];
                default: begin
                    if (a[3:0] == 4'd0) m_bank_en = d[0];
                    if (a[3:0] == 4'd1) m_bank = d[3:0];
                end
            endcase
        end
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R4: supervisor identity readback; R5: user entries denied and zero.
        for (int i = 0; i < 16; i++) begin
            access(1'b1, 1'b0, 16'hFFC0 + 16'(i), 8'd0, 1'b1);
            chk("R4 identity", rdata, 8'(i));
            access(1'b1, 1'b0, 16'hFFE0 + 16'(i), 8'd0, 1'b1);
            access(1'b1, 1'b0, 16'hFFD0 + 16'(i), 8'd0, 1'b1);
        end
        access(1'b1, 1'b0, 16'hFFF0, 8'd0, 1'b1);
        access(1'b1, 1'b0, 16'hFFF1, 8'd0, 1'b1);
        // R5: user access faults after reset.
        access(1'b1, 1'b0, 16'h3456, 8'd0, 1'b0);
        chk("R5 user denied", {fault, mem_sel}, 2'b10);

        // R2: supervisor remap of page 5.
        access(1'b1, 1'b1, 16'hFFC5, 8'hA7, 1'b1);
        access(1'b1, 1'b0, 16'h5ABC, 8'd0, 1'b1);
        chk("R2 remap", pa, 20'hA7ABC);

        // R8: user write attempt then supervisor readback shows no change.
        access(1'b1, 1'b1, 16'hFFC5, 8'h11, 1'b0);
        access(1'b1, 1'b0, 16'hFFC5, 8'd0, 1'b1);
        chk("R8 table unchanged", rdata, 8'hA7);

        // R3 and R9: open user page 2 and map it.
        access(1'b1, 1'b1, 16'hFFD2, 8'h3C, 1'b1);
        access(1'b1, 1'b1, 16'hFFE2, 8'h00, 1'b1);
        access(1'b1, 1'b0, 16'h2F00, 8'd0, 1'b0);
        chk("R3 user map", {mem_sel, pa}, {1'b1, 20'h3CF00});
        access(1'b1, 1'b1, 16'hFFE2, 8'h01, 1'b1);
        access(1'b1, 1'b0, 16'h2F00, 8'd0, 1'b0);
        chk("R9 deny again", {fault, mem_sel}, 2'b10);

        // R10: bank mode example.
        access(1'b1, 1'b1, 16'hFFF1, 8'h03, 1'b1);
        access(1'b1, 1'b1, 16'hFFF0, 8'h01, 1'b1);
        access(1'b1, 1'b0, 16'hC000, 8'd0, 1'b1);
        chk("R10 example", pa, 20'h1C000);
        access(1'b1, 1'b0, 16'h1234, 8'd0, 1'b1);
        chk("R10 lower half", pa, 20'h01234);
        // R6: window still reachable in bank mode.
        access(1'b1, 1'b0, 16'hFFF1, 8'd0, 1'b1);
        chk("R6 window in bank mode", rdata, 8'h03);
        access(1'b1, 1'b1, 16'hFFF0, 8'h00, 1'b1);

        // R11: idle cycle.
        access(1'b0, 1'b0, 16'h8000, 8'd0, 1'b1);

        // Random mix with a fixed seed.
        void'($urandom(32'd20240611));
        for (int n = 0; n < 4000; n++) begin
            logic [15:0] a;
            a = 16'($urandom);
            if ($urandom % 3 == 0) a = {10'h3FF, 6'($urandom)};
            access(($urandom % 8) != 0, $urandom % 2 == 1, a, 8'($urandom),
                   $urandom % 2 == 1);
        end

        done = 1'b1;
        finish_run();
    end

endmodule